// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock time and date: seconds, minutes, hours, day of week, day of month, month, year within the century, and century. Its time base is a one-cycle enable pulse `tick` at 32.768 kHz. A divider turns the tick into a one-second update and also into a programmable periodic event. Leap years are handled, and so is an optional daylight-saving shift.

Software reaches everything through a small byte-wide register port. The counting registers sit behind a host-visible copy, so a read never observes a half-finished update. A freeze control bit halts counting while new time values are staged. Clearing it commits all the staged values in one cycle.

Three event flags report the periodic event, an alarm match and the end of each update. Each flag has an enable. A single interrupt output is active when any enabled flag is set.

Top module: `rtc_core`

Register addresses used below: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century, 8 alarm seconds, 9 alarm minutes, 10 alarm hours, 11 rate (bits 3:0), 12 control, 13 flags. Control bits: 7 freeze, 6 periodic enable, 5 alarm enable, 4 update enable, 2 binary format, 0 daylight saving. Flag bits: 7 interrupt, 6 periodic, 5 alarm, 4 update.

## Requirements
- R1: After reset the block holds 00:00:00 on day-of-week 1, date 01, month 01, year 00, century 20. It is in BCD format, all flags read 0x00 and `irq` is low.
- R2: Seconds advance once per 2^DIV_BITS ticks. Carries ripple from seconds (0-59) to minutes (0-59), hours (0-23), day of week (7 wraps to 1), date (1 up to the month's length), month (1-12), year (0-99) and century (0-99).
- R3: February has 29 days when year mod 4 is 0, except year 00 unless century mod 4 is 0. Otherwise it has 28 days.
- R4: With control bit 2 clear, time and alarm values are read and written as packed BCD. With it set, they are plain binary.
- R5: While control bit 7 is set, counting stops and no update or alarm flag is raised. Writes to addresses 0-7 are staged, and clearing the bit commits them. Writes to addresses 0-7 while the bit is clear are ignored.
- R6: Reads of addresses 0-7 come from the buffered copy. During freeze they return the staged values.
- R7: Rate code 0 disables the periodic event. Codes 3-15 give a period of 2^(code-1) ticks. Codes 1 and 2 behave as 8 and 9. Each event sets flag bit 6.
- R8: At an update, flag bit 5 is set when the new seconds, minutes and hours match the alarm. An alarm byte with bits 7:6 both set matches any value of its field.
- R9: Every update sets flag bit 4.
- R10: Reading address 13 returns the flags, with bit 7 equal to `irq`, and clears them. A flag raised in the same cycle survives the clear.
- R11: `irq` is high exactly when some flag is set together with its enable (bit 6 with control bit 6, bit 5 with bit 5, bit 4 with bit 4).
- R12: With control bit 0 set, the update out of 01:59:59 behaves as follows. On a Sunday (day of week 1) in April dated 1-7 it goes to 03:00:00. On a Sunday in October dated 25 or later it goes to 01:00:00, once only; the next pass out of hour 1 goes to 02:00:00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 32.768 kHz time-base enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags at address 13) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the addressed register |
| irq | output | 1 | Combined interrupt request |

## Verification
`rdata` follows `addr` in the same cycle. The time fields, the update flag and the alarm flag change on the clock edge that samples the last tick of a second. The periodic flag changes on the edge of its tick. A flag read clears on the edge that samples `rd_en`. The bench drives inputs on the falling edge and samples one nanosecond later. Every tick burst is an exact count, so each expected value is fixed by arithmetic on the divider phase, which starts at zero after reset and is kept a multiple of the second length between tests.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 8;
  localparam int AW     = 4;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  localparam logic [AW-1:0] A_ALM0  = 4'd8;
  localparam logic [AW-1:0] A_RATE  = 4'd11;
  localparam logic [AW-1:0] A_CTRL  = 4'd12;
  localparam logic [AW-1:0] A_FLAGS = 4'd13;
  localparam logic [7:0]    CTRL_MASK = 8'hF5;

  typedef logic [6:0] fld_t;
  typedef fld_t [NFIELD-1:0] tvec_t;

  function automatic tvec_t time_at_reset();
    tvec_t t;
    t = '0;
    t[F_DOW]  = 7'd1;
    t[F_DATE] = 7'd1;
    t[F_MON]  = 7'd1;
    t[F_CENT] = 7'd20;
    return t;
  endfunction

  function automatic logic [7:0] to_bcd(input fld_t v);
    logic [7:0] w;
    w = {1'b0, v};
    return ((w / 8'd10) << 4) | (w % 8'd10);
  endfunction

  function automatic fld_t from_bcd(input logic [7:0] b);
    return 7'({3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]});
  endfunction

  function automatic fld_t month_len(input fld_t mon, input fld_t yr, input fld_t cen);
    logic leap;
    leap = (yr[1:0] == 2'd0) && ((yr != 7'd0) || (cen[1:0] == 2'd0));
    case (mon)
      7'd2:                      return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] rate,
  output logic       sec_p,
  output logic       per_p
);
  logic [DIV_BITS-1:0] cnt_q, cnt_d, mask;
  logic [3:0]          eff;

  always_comb begin
    cnt_d = tick ? cnt_q + 1'b1 : cnt_q;
    eff   = (rate == 4'd1 || rate == 4'd2) ? rate + 4'd7 : rate;
    for (int i = 0; i < DIV_BITS; i++) begin
      mask[i] = ((i + 1) < int'(eff));
    end
    sec_p = tick && (&cnt_q);
    per_p = tick && (rate != 4'd0) && ((cnt_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  load,
  input  tvec_t load_val,
  input  logic  dst_en,
  output tvec_t q,
  output tvec_t d
);
  logic fell_q, fell_d;
  logic at_edge, spring, fall;

  always_comb begin
    d      = q;
    fell_d = fell_q;
    at_edge = (q[F_HOUR] == 7'd1) && (q[F_MIN] == 7'd59) && (q[F_SEC] == 7'd59)
              && (q[F_DOW] == 7'd1) && dst_en;
    spring = at_edge && (q[F_MON] == 7'd4)  && (q[F_DATE] <= 7'd7);
    fall   = at_edge && (q[F_MON] == 7'd10) && (q[F_DATE] >= 7'd25) && !fell_q;
    if (load) begin
      d = load_val;
    end else if (adv) begin
      if (spring) begin
        d[F_HOUR] = 7'd3; d[F_MIN] = '0; d[F_SEC] = '0;
      end else if (fall) begin
        d[F_HOUR] = 7'd1; d[F_MIN] = '0; d[F_SEC] = '0;
        fell_d = 1'b1;
      end else if (q[F_SEC] != 7'd59) begin
        d[F_SEC] = q[F_SEC] + 7'd1;
      end else begin
        d[F_SEC] = '0;
        if (q[F_MIN] != 7'd59) begin
          d[F_MIN] = q[F_MIN] + 7'd1;
        end else begin
          d[F_MIN] = '0;
          fell_d   = 1'b0;
          if (q[F_HOUR] != 7'd23) begin
            d[F_HOUR] = q[F_HOUR] + 7'd1;
          end else begin
            d[F_HOUR] = '0;
            d[F_DOW]  = (q[F_DOW] == 7'd7) ? 7'd1 : q[F_DOW] + 7'd1;
            if (q[F_DATE] != month_len(q[F_MON], q[F_YEAR], q[F_CENT])) begin
              d[F_DATE] = q[F_DATE] + 7'd1;
            end else begin
              d[F_DATE] = 7'd1;
              if (q[F_MON] != 7'd12) begin
                d[F_MON] = q[F_MON] + 7'd1;
              end else begin
                d[F_MON] = 7'd1;
                if (q[F_YEAR] != 7'd99) begin
                  d[F_YEAR] = q[F_YEAR] + 7'd1;
                end else begin
                  d[F_YEAR] = '0;
                  d[F_CENT] = (q[F_CENT] == 7'd99) ? 7'd0 : q[F_CENT] + 7'd1;
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= time_at_reset();
      fell_q <= 1'b0;
    end else begin
      q      <= d;
      fell_q <= fell_d;
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq
);
  logic [1:0]      rsync_q;
  logic            rst_sn;
  logic            sec_p, per_p, adv, load, alarm_hit, freeze_q, bin_q;
  tvec_t           cal_q, cal_d, shadow_q, shadow_d;
  logic [2:0][7:0] alm_q, alm_d;
  logic [3:0]      rate_q, rate_d;
  logic [7:0]      ctrl_q, ctrl_d;
  logic [2:0]      flags_q, flags_d;
  fld_t            wval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  rtc_prescale #(.DIV_BITS(DIV_BITS)) u_pre (
    .clk(clk), .rst_n(rst_sn), .tick(tick), .rate(rate_q),
    .sec_p(sec_p), .per_p(per_p)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_sn), .adv(adv), .load(load), .load_val(shadow_q),
    .dst_en(ctrl_q[0]), .q(cal_q), .d(cal_d)
  );

  assign freeze_q = ctrl_q[7];
  assign bin_q    = ctrl_q[2];
  assign adv      = sec_p && !freeze_q;
  assign load     = wr_en && (addr == A_CTRL) && !wdata[7] && freeze_q;
  assign wval     = bin_q ? wdata[6:0] : from_bcd(wdata);
  assign irq      = |(flags_q & ctrl_q[6:4]);

  always_comb begin
    alarm_hit = 1'b1;
    for (int i = 0; i < 3; i++) begin
      if (alm_q[i][7:6] != 2'b11) begin
        if ((bin_q ? alm_q[i][6:0] : from_bcd(alm_q[i])) != cal_d[i]) alarm_hit = 1'b0;
      end
    end
  end

  always_comb begin
    shadow_d = shadow_q;
    alm_d    = alm_q;
    rate_d   = rate_q;
    ctrl_d   = ctrl_q;
    if (!freeze_q) shadow_d = cal_d;
    if (wr_en) begin
      if (!addr[3]) begin
        if (freeze_q) shadow_d[addr[2:0]] = wval;
      end else if (addr < A_RATE) begin
        alm_d[addr[1:0]] = wdata;
      end else if (addr == A_RATE) begin
        rate_d = wdata[3:0];
      end else if (addr == A_CTRL) begin
        ctrl_d = wdata & CTRL_MASK;
      end
    end
    flags_d = ((rd_en && addr == A_FLAGS) ? 3'b000 : flags_q)
              | {per_p, adv && alarm_hit, adv};
  end

  always_comb begin
    rdata = 8'h00;
    if (!addr[3]) begin
      rdata = bin_q ? {1'b0, shadow_q[addr[2:0]]} : to_bcd(shadow_q[addr[2:0]]);
    end else if (addr < A_RATE) begin
      rdata = alm_q[addr[1:0]];
    end else if (addr == A_RATE) begin
      rdata = {4'b0, rate_q};
    end else if (addr == A_CTRL) begin
      rdata = ctrl_q;
    end else if (addr == A_FLAGS) begin
      rdata = {irq, flags_q, 4'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      shadow_q <= time_at_reset();
      alm_q    <= '0;
      rate_q   <= '0;
      ctrl_q   <= '0;
      flags_q  <= '0;
    end else begin
      shadow_q <= shadow_d;
      alm_q    <= alm_d;
      rate_q   <= rate_d;
      ctrl_q   <= ctrl_d;
      flags_q  <= flags_d;
    end
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst_sn,
  input logic       adv,
  input logic       load,
  input logic       freeze_q,
  input tvec_t      cal_q,
  input logic [2:0] flags_q,
  input logic [3:0] rate_q,
  input logic       per_p,
  input logic       irq
);
  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (adv && cal_q[F_SEC] == 7'd59) |=> (cal_q[F_SEC] == 7'd0));

  assert_sec_moves_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    adv |=> !$stable(cal_q[F_SEC]));

  assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (freeze_q && !load) |=> $stable(cal_q));

  assert_update_flag_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    adv |=> flags_q[0]);

  assert_rate_off_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (rate_q == 4'd0) |-> !per_p);

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> (flags_q != 3'b000));
endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk(clk), .rst_sn(rst_sn), .adv(adv), .load(load), .freeze_q(freeze_q),
  .cal_q(cal_q), .flags_q(flags_q), .rate_q(rate_q), .per_p(per_p), .irq(irq)
);

// File: tb/rtc_core_test.sv
module rtc_core_test;
  logic       clk = 1'b0;
  logic       rst_n, tick, wr_en, rd_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         chk_q[$];

  rtc_core #(.DIV_BITS(4)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t); chk_q.push_back(1'b1);
    addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_drop(input logic [3:0] a);
    @(negedge clk);
    exp_q.push_back(8'h00); tag_q.push_back("drop"); chk_q.push_back(1'b0);
    addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk); #1;
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
    end
  endtask

  always begin
    @(negedge clk); #1;
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string      t;
      bit         c;
      e = exp_q.pop_front(); t = tag_q.pop_front(); c = chk_q.pop_front();
      if (c) begin
        total++;
        if (rdata !== e) begin
          bad++;
          $display("FAIL %s: rdata got %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(4'd0, 8'h00, "R1 sec");
    rd(4'd2, 8'h00, "R1 hour");
    rd(4'd3, 8'h01, "R1 dow");
    rd(4'd4, 8'h01, "R1 date");
    rd(4'd7, 8'h20, "R1 century");
    rd(4'd13, 8'h00, "R1 flags");
    chk_irq(1'b0, "R1 irq");

    // R6 staged values visible during freeze, R2 full rollover
    wr(4'd12, 8'h80);
    wr(4'd0, 8'h58); wr(4'd1, 8'h59); wr(4'd2, 8'h23); wr(4'd3, 8'h07);
    wr(4'd4, 8'h31); wr(4'd5, 8'h12); wr(4'd6, 8'h99); wr(4'd7, 8'h20);
    rd(4'd0, 8'h58, "R6 staged sec");
    rd(4'd4, 8'h31, "R6 staged date");
    wr(4'd12, 8'h00);
    run(16);
    rd(4'd0, 8'h59, "R2 one second");
    rd(4'd13, 8'h10, "R9 update flag");
    rd(4'd13, 8'h00, "R10 cleared by read");
    run(16);
    rd(4'd0, 8'h00, "R2 sec wrap");
    rd(4'd1, 8'h00, "R2 min wrap");
    rd(4'd2, 8'h00, "R2 hour wrap");
    rd(4'd3, 8'h01, "R2 dow wrap");
    rd(4'd4, 8'h01, "R2 date wrap");
    rd(4'd5, 8'h01, "R2 month wrap");
    rd(4'd6, 8'h00, "R2 year wrap");
    rd(4'd7, 8'h21, "R2 century carry");

    // R5 writes ignored when not frozen, counting halted when frozen
    wr(4'd0, 8'h30);
    rd(4'd0, 8'h00, "R5 write ignored");
    rd_drop(4'd13);
    wr(4'd12, 8'h80);
    run(32);
    rd(4'd0, 8'h00, "R5 frozen count");
    rd(4'd13, 8'h00, "R5 no update flag");

    // R3 leap years
    wr(4'd6, 8'h24); wr(4'd7, 8'h20); wr(4'd5, 8'h02); wr(4'd4, 8'h28);
    wr(4'd2, 8'h23); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    wr(4'd12, 8'h00);
    run(16);
    rd(4'd4, 8'h29, "R3 year 24 leap");
    wr(4'd12, 8'h80);
    wr(4'd6, 8'h00); wr(4'd4, 8'h28); wr(4'd2, 8'h23); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    wr(4'd12, 8'h00);
    run(16);
    rd(4'd4, 8'h29, "R3 century 20 year 00 leap");
    wr(4'd12, 8'h80);
    wr(4'd7, 8'h21); wr(4'd4, 8'h28); wr(4'd2, 8'h23); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    wr(4'd12, 8'h00);
    run(16);
    rd(4'd4, 8'h01, "R3 century 21 year 00 date");
    rd(4'd5, 8'h03, "R3 century 21 year 00 month");

    // R4 binary and BCD formats
    wr(4'd12, 8'h84);
    wr(4'd0, 8'h3A);
    wr(4'd12, 8'h04);
    run(16);
    rd(4'd0, 8'h3B, "R4 binary read");
    wr(4'd12, 8'h00);
    rd(4'd0, 8'h59, "R4 bcd read");

    // R8 alarm with don't-care minutes, R11 irq
    rd_drop(4'd13);
    wr(4'd12, 8'h80);
    wr(4'd2, 8'h10); wr(4'd1, 8'h20); wr(4'd0, 8'h29);
    wr(4'd8, 8'h30); wr(4'd9, 8'hC0); wr(4'd10, 8'h10);
    wr(4'd12, 8'h20);
    run(16);
    chk_irq(1'b1, "R11 alarm irq");
    rd(4'd13, 8'hB0, "R8 alarm match");
    chk_irq(1'b0, "R10 irq after clear");
    run(16);
    rd(4'd13, 8'h10, "R8 no match");
    chk_irq(1'b0, "R11 masked update");

    // R7 periodic rates
    wr(4'd12, 8'h00);
    wr(4'd11, 8'h04);
    run(7);
    rd(4'd13, 8'h00, "R7 rate4 early");
    run(1);
    rd(4'd13, 8'h40, "R7 rate4 event");
    run(8);
    rd(4'd13, 8'h50, "R7 rate4 second event");
    wr(4'd12, 8'h40);
    wr(4'd11, 8'h00);
    run(16);
    chk_irq(1'b0, "R7 rate0 irq");
    rd(4'd13, 8'h10, "R7 rate0 off");
    wr(4'd11, 8'h03);
    run(3);
    rd(4'd13, 8'h00, "R7 rate3 early");
    run(1);
    chk_irq(1'b1, "R11 periodic irq");
    rd(4'd13, 8'hC0, "R7 rate3 event");
    run(12);
    wr(4'd11, 8'h00);
    rd_drop(4'd13);

    // R12 daylight saving
    wr(4'd12, 8'h81);
    wr(4'd5, 8'h04); wr(4'd4, 8'h03); wr(4'd3, 8'h01);
    wr(4'd2, 8'h01); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    wr(4'd12, 8'h01);
    run(16);
    rd(4'd2, 8'h03, "R12 spring hour");
    rd(4'd1, 8'h00, "R12 spring min");
    wr(4'd12, 8'h81);
    wr(4'd5, 8'h10); wr(4'd4, 8'h27); wr(4'd3, 8'h01);
    wr(4'd2, 8'h01); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    wr(4'd12, 8'h01);
    run(16);
    rd(4'd2, 8'h01, "R12 fall hour");
    rd(4'd1, 8'h00, "R12 fall min");
    wr(4'd12, 8'h81);
    wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    wr(4'd12, 8'h01);
    run(16);
    rd(4'd2, 8'h02, "R12 fall once");
    wr(4'd12, 8'h80);
    wr(4'd5, 8'h04); wr(4'd4, 8'h03); wr(4'd3, 8'h01);
    wr(4'd2, 8'h01); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    wr(4'd12, 8'h00);
    run(16);
    rd(4'd2, 8'h02, "R12 disabled");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule